// File: doc/BRIEF.md
# Embedded-Clock Pixel Frame Serializer

This block takes one pixel of parallel video per pixel-clock period and sends it as a fixed 28-slot serial frame. The slots run at the bit clock, which is 28 times the pixel clock. Every frame opens with a forced high slot and closes with a forced low slot, so the line has a rising edge at each frame boundary that a receiver can lock its clock to. The three timing signals are folded into two control slots in the middle of the frame. Both control slots are sent in the clear. The 24 colour bits are XORed with an additive scrambler, which spreads the line energy and keeps the line roughly DC balanced for AC coupling.

The whole block runs on the bit clock. The pixel clock comes in as a level and is sampled each bit clock. A polarity input selects whether a rising or a falling pixel-clock transition captures the parallel inputs. Each capture starts a new frame. When captures stop, the line falls quiet at zero. A one-slot marker flags the slot that carries the leading high bit.

Top module: `pix_frame_serializer`

## Requirements
- R1: Each capture produces exactly 28 serial slots. With a pixel clock of exactly 28 bit clocks, frames follow one another with no gap, and `frame_start_o` pulses every 28 bit clocks.
- R2: Slot 0 of a frame is always 1 and is never scrambled. Slot 27 is always 0. `frame_start_o` is high during slot 0 only.
- R3: Slots are sent in this order: slots 1..12 carry colour[23:12] MSB first, slot 13 carries the first control bit, slot 14 carries the second control bit, and slots 15..26 carry colour[11:0] MSB first.
- R4: The first control bit is DE XOR VS. The second control bit is DE XOR HS. Both are sent unscrambled.
- R5: Each colour slot is XORed with bit 14 of a 15-bit register. After each colour slot the register steps to {r[13:0], r[14]^r[13]}. It does not step in any other slot or while the line is idle. It holds the seed 15'h4A5F while reset is high.
- R6: The inputs are captured on the pixel-clock transition that `cap_fall_i` selects (0 for rising, 1 for falling), as seen by the bit clock. Input values present at any other time have no effect on the frame.
- R7: Assume the pixel-clock level changes between two bit-clock rising edges. Then `frame_start_o` is high after the third bit-clock rising edge that follows the change.
- R8: If no new capture arrives after slot 27, `serial_o` and `frame_start_o` stay 0.
- R9: While `rst_i` is high, `serial_o` and `frame_start_o` are 0 and no frame is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, 28 times the pixel rate |
| rst_i | input | 1 | Synchronous active-high reset; also reseeds the scrambler |
| pclk_i | input | 1 | Pixel clock level, sampled on clk_i |
| cap_fall_i | input | 1 | Capture edge select: 0 rising, 1 falling |
| rgb_i | input | 24 | Colour word of the pixel |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Data enable |
| serial_o | output | 1 | Serial line, one slot per clk_i |
| frame_start_o | output | 1 | High during the leading-1 slot of each frame |

## Verification
A capture is defined as the bit-clock sample that first sees the pixel clock at its new level. Three bit-clock edges after the level change, the leading slot and `frame_start_o` appear, and the remaining 27 slots follow on the next 27 edges. The driver records the bit-clock count at each pixel-clock transition and pushes it into a queue together with the expected colour and control bits. The monitor samples on the falling bit-clock edge. When it sees `frame_start_o`, it checks the three-cycle latency against the recorded count. It then gathers 28 slots, descrambles them with its own model of the key register, and compares the result with the popped entry. The bench also drives junk data between captures and measures the frame spacing on back-to-back pixels.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int PFS_COLOR_W = 24;
  localparam int PFS_KEY_W   = 15;
  localparam logic [PFS_KEY_W-1:0] PFS_KEY_SEED = 15'h4A5F;
  // start + stop + two control slots around the colour payload
  localparam int PFS_OVERHEAD = 4;
endpackage

// File: rtl/pfs_pclk_edge.sv
module pfs_pclk_edge (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pclk_i,
  input  logic fall_sel_i,
  output logic capture_o
);
  logic lvl_q;
  logic lvl_prev_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      lvl_q      <= 1'b0;
      lvl_prev_q <= 1'b0;
    end else begin
      lvl_q      <= pclk_i;
      lvl_prev_q <= lvl_q;
    end
  end

  always_comb begin
    if (fall_sel_i) capture_o = ~lvl_q & lvl_prev_q;
    else            capture_o = lvl_q & ~lvl_prev_q;
  end

  AST_CAPTURE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    capture_o |=> !capture_o); // R6
endmodule

// File: rtl/pfs_scrambler.sv
module pfs_scrambler #(
  parameter int KEY_W = pfs_pkg::PFS_KEY_W,
  parameter logic [KEY_W-1:0] SEED = pfs_pkg::PFS_KEY_SEED
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic step_i,
  output logic key_o
);
  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)       key_q <= SEED;
    else if (step_i) key_q <= {key_q[KEY_W-2:0], key_q[KEY_W-1] ^ key_q[KEY_W-2]};
  end

  assign key_o = key_q[KEY_W-1];

  AST_KEY_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    key_q != '0); // R5
  AST_KEY_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    !step_i |=> $stable(key_q)); // R5
endmodule

// File: rtl/pfs_frame_shifter.sv
module pfs_frame_shifter #(
  parameter int COLOR_W = pfs_pkg::PFS_COLOR_W
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               load_i,
  input  logic [COLOR_W-1:0] color_i,
  input  logic               ctrl_a_i,
  input  logic               ctrl_b_i,
  output logic               bit_o,
  output logic               busy_o,
  output logic               lead_o,
  output logic               color_slot_o
);
  localparam int HALF    = COLOR_W / 2;
  localparam int FRAME_W = COLOR_W + pfs_pkg::PFS_OVERHEAD;
  localparam int SLOT_W  = $clog2(FRAME_W);
  localparam logic [SLOT_W-1:0] S_HI_FIRST = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] S_HI_LAST  = SLOT_W'(HALF);
  localparam logic [SLOT_W-1:0] S_LO_FIRST = SLOT_W'(HALF + 3);
  localparam logic [SLOT_W-1:0] S_LO_LAST  = SLOT_W'(2 * HALF + 2);
  localparam logic [SLOT_W-1:0] S_END      = SLOT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] shift_q;
  logic [SLOT_W-1:0]  slot_q;
  logic               busy_q;
  logic [FRAME_W-1:0] frame_d;

  assign frame_d = {1'b1, color_i[COLOR_W-1:HALF], ctrl_a_i, ctrl_b_i,
                    color_i[HALF-1:0], 1'b0};

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      shift_q <= '0;
      slot_q  <= '0;
      busy_q  <= 1'b0;
    end else if (load_i) begin
      shift_q <= frame_d;
      slot_q  <= '0;
      busy_q  <= 1'b1;
    end else if (busy_q) begin
      shift_q <= {shift_q[FRAME_W-2:0], 1'b0};
      if (slot_q == S_END) begin
        slot_q <= '0;
        busy_q <= 1'b0;
      end else begin
        slot_q <= slot_q + SLOT_W'(1);
      end
    end
  end

  assign bit_o        = shift_q[FRAME_W-1];
  assign busy_o       = busy_q;
  assign lead_o       = busy_q && (slot_q == '0);
  assign color_slot_o = busy_q &&
                        (((slot_q >= S_HI_FIRST) && (slot_q <= S_HI_LAST)) ||
                         ((slot_q >= S_LO_FIRST) && (slot_q <= S_LO_LAST)));

  AST_SLOT_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
    slot_q <= S_END); // R1
  AST_START_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q && slot_q == '0) |-> shift_q[FRAME_W-1]); // R2
  AST_STOP_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (busy_q && slot_q == S_END) |-> !shift_q[FRAME_W-1]); // R2
endmodule

// File: rtl/pix_frame_serializer.sv
module pix_frame_serializer #(
  parameter int COLOR_W = pfs_pkg::PFS_COLOR_W,
  parameter int KEY_W   = pfs_pkg::PFS_KEY_W,
  parameter logic [KEY_W-1:0] SEED = pfs_pkg::PFS_KEY_SEED
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               pclk_i,
  input  logic               cap_fall_i,
  input  logic [COLOR_W-1:0] rgb_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  input  logic               de_i,
  output logic               serial_o,
  output logic               frame_start_o
);
  logic capture;
  logic cur_bit;
  logic busy;
  logic lead;
  logic color_slot;
  logic key_bit;
  logic serial_q;
  logic start_q;

  pfs_pclk_edge i_edge (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .pclk_i     (pclk_i),
    .fall_sel_i (cap_fall_i),
    .capture_o  (capture)
  );

  pfs_frame_shifter #(.COLOR_W(COLOR_W)) i_shift (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .load_i       (capture),
    .color_i      (rgb_i),
    .ctrl_a_i     (de_i ^ vsync_i),
    .ctrl_b_i     (de_i ^ hsync_i),
    .bit_o        (cur_bit),
    .busy_o       (busy),
    .lead_o       (lead),
    .color_slot_o (color_slot)
  );

  pfs_scrambler #(.KEY_W(KEY_W), .SEED(SEED)) i_scr (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .step_i (color_slot),
    .key_o  (key_bit)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      serial_q <= 1'b0;
      start_q  <= 1'b0;
    end else begin
      serial_q <= busy & (cur_bit ^ (color_slot & key_bit));
      start_q  <= lead;
    end
  end

  assign serial_o      = serial_q;
  assign frame_start_o = start_q;

  AST_START_IS_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_start_o |-> serial_o); // R2
  AST_START_ONE_SLOT: assert property (@(posedge clk_i) disable iff (rst_i)
    frame_start_o |=> !frame_start_o); // R1
endmodule

// File: tb/test_pix_frame_serializer.sv
module test_pix_frame_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME      = 28;
  localparam logic [14:0] SEED = 15'h4A5F;

  typedef struct {
    logic [23:0] rgb;
    logic        ca;
    logic        cb;
    int          edge_cyc;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pclk = 1'b0;
  logic        pol = 1'b0;
  logic [23:0] rgb = '0;
  logic        hs = 1'b0;
  logic        vs = 1'b0;
  logic        de = 1'b0;
  logic        sdo;
  logic        fs;

  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  exp_t expq[$];

  pix_frame_serializer i_pix_frame_serializer (
    .clk_i(clk), .rst_i(rst), .pclk_i(pclk), .cap_fall_i(pol),
    .rgb_i(rgb), .hsync_i(hs), .vsync_i(vs), .de_i(de),
    .serial_o(sdo), .frame_start_o(fs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // driver: one pixel per 28 bit clocks, junk on the inputs between captures
  task automatic send_pixel(input logic [23:0] c, input logic h, input logic v, input logic e);
    exp_t it;
    logic act_lvl;
    act_lvl = ~pol;
    if (pclk == act_lvl) begin
      pclk = ~act_lvl;
      repeat (14) @(negedge clk);
    end
    rgb = c; hs = h; vs = v; de = e;
    pclk = act_lvl;
    it.rgb = c; it.ca = e ^ v; it.cb = e ^ h; it.edge_cyc = cyc;
    expq.push_back(it);
    repeat (2) @(negedge clk);
    rgb = ~c; hs = ~h; vs = ~v; de = ~e;   // R6: must not reach the frame
    repeat (12) @(negedge clk);
    pclk = ~act_lvl;
    repeat (14) @(negedge clk);
  endtask

  // monitor: deserialize, descramble, compare
  initial begin : monitor
    logic [14:0]      m;
    logic [FRAME-1:0] fr;
    int               fs_cyc;
    int               last_fs;
    int               last_edge;
    m = SEED;
    last_fs = -1000;
    last_edge = -1000;
    forever begin
      @(negedge clk);
      if (rst) begin
        m = SEED;
        continue;
      end
      if (fs) begin
        exp_t        it;
        logic [23:0] got;
        fs_cyc = cyc;
        fr[FRAME-1] = sdo;
        for (int i = 1; i < FRAME; i++) begin
          @(negedge clk);
          fr[FRAME-1-i] = sdo;
          check(fs == 1'b0, "R2 marker outside slot 0", fs, 0);
        end
        for (int s = 1; s <= 26; s++) begin
          logic b;
          b = fr[FRAME-1-s];
          if ((s >= 1 && s <= 12) || (s >= 15 && s <= 26)) begin
            b = b ^ m[14];
            m = {m[13:0], m[14] ^ m[13]};
            if (s <= 12) got[24-s] = b;
            else         got[26-s] = b;
          end
        end
        check(fr[FRAME-1] == 1'b1, "R2 start slot", fr[FRAME-1], 1);
        check(fr[0] == 1'b0, "R2 stop slot", fr[0], 0);
        if (expq.size() == 0) begin
          check(1'b0, "R1 unexpected frame", 1, 0);
        end else begin
          it = expq.pop_front();
          check(got == it.rgb, "R3 R5 R6 colour", int'(got), int'(it.rgb));
          check(fr[14] == it.ca, "R4 first control slot", fr[14], it.ca);
          check(fr[13] == it.cb, "R4 second control slot", fr[13], it.cb);
          check(fs_cyc - it.edge_cyc == 3, "R7 start latency", fs_cyc - it.edge_cyc, 3);
          if (it.edge_cyc - last_edge == FRAME)
            check(fs_cyc - last_fs == FRAME, "R1 frame spacing", fs_cyc - last_fs, FRAME);
          last_edge = it.edge_cyc;
        end
        last_fs = fs_cyc;
      end
    end
  end

  task automatic idle_check(input string tag);
    repeat (40) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      check(sdo == 1'b0 && fs == 1'b0, tag, {sdo, fs}, 0);
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    repeat (5) @(negedge clk);
    check(sdo == 1'b0, "R9 reset serial", sdo, 0);
    check(fs == 1'b0, "R9 reset marker", fs, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // rising-edge capture, back-to-back, all timing combinations
    send_pixel(24'h000000, 1'b0, 1'b0, 1'b0);
    send_pixel(24'hFFFFFF, 1'b0, 1'b0, 1'b1);
    send_pixel(24'hA5A5A5, 1'b1, 1'b0, 1'b0);
    send_pixel(24'h800001, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 8; i++)
      send_pixel(24'h0B1D37 * (i + 1) ^ (24'h1 << (i * 3)), i[1], i[2], i[0]);
    idle_check("R8 idle after rising stream");

    // falling-edge capture; key register must have held through the gap
    pol = 1'b1;
    for (int i = 0; i < 8; i++)
      send_pixel(24'hC3E1F0 ^ (24'h5 << (i * 2)), i[0], i[1], i[2]);
    idle_check("R8 idle after falling stream");

    // reset reseeds the key register
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(sdo == 1'b0 && fs == 1'b0, "R9 outputs in second reset", {sdo, fs}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    send_pixel(24'h123456, 1'b1, 1'b1, 1'b0);
    send_pixel(24'hFEDCBA, 1'b0, 1'b0, 1'b1);
    send_pixel(24'h000001, 1'b1, 1'b0, 1'b1);
    send_pixel(24'h7FFFFE, 1'b0, 1'b1, 1'b1);
    repeat (40) @(negedge clk);
    check(expq.size() == 0, "R1 every capture framed", expq.size(), 0);
    finish_run();
  end
endmodule